// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and a byte-wide asynchronous static RAM with 17 address bits (131,072 bytes). It takes a single-cycle request over a valid/ready handshake and drives the active-low chip-select, output-enable and write-strobe lines. It also drives the address and a bidirectional 8-bit data bus. Each access is stretched over enough clock cycles to meet the memory's minimum timing.

Every minimum interval is given as a nanosecond parameter: strobe pulse width, write-data setup, address hold, read access, output-enable access and bus release. The block converts each one to clocks by rounding up against a clock-period parameter, with a floor of one cycle. A read returns its byte with a one-cycle valid flag. A write ends with a one-cycle done pulse. The memory's output drivers and the controller's own driver are never enabled together, and a write can only begin once the bus-release time after a read has passed.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, all three strobes are high, the data driver is off, `req_ready` is high, and `rd_valid` and `wr_done` are low.
- R2: A write holds chip-select and write-strobe low together for exactly max(ceil(T_WP_NS/CLK_PERIOD_NS), ceil(T_DS_NS/CLK_PERIOD_NS)) cycles, which is 11 at the defaults. Output-enable stays high throughout. Every ns-to-cycle conversion rounds up, with a minimum of 1.
- R3: During every write-strobe-low cycle, the controller drives the request's write data onto the bus, and the value does not change.
- R4: The address equals the request address and stays constant while write-strobe is low. It also stays constant for ceil(T_AH_NS/CLK_PERIOD_NS) cycles after write-strobe rises (1 at the defaults).
- R5: A read holds chip-select and output-enable low, with write-strobe high, for exactly max(ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS)) cycles, which is 14 at the defaults. The controller's driver stays off during this window.
- R6: `rd_valid` is high for exactly the one cycle in which chip-select and output-enable have just returned high. In that cycle, `rd_data` holds the bus value captured at the clock edge that ended the read window.
- R7: The controller's data driver is never enabled while output-enable is low. After output-enable rises, the driver stays off for at least ceil(T_BUS_TURN_NS/CLK_PERIOD_NS) cycles (4 at the defaults).
- R8: `wr_done` is a one-cycle pulse. It arrives in the cycle that follows the address-hold cycles after write-strobe rises, and `req_ready` is high in that cycle.
- R9: `req_ready` is high only when no access is in progress, and every strobe is high whenever it is. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low for exactly write-pulse + hold cycles for a write (12), or read-window + release cycles for a read (18).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle flag: rd_data holds the read byte |
| rd_data | output | 8 | Byte returned by the last read |
| wr_done | output | 1 | One-cycle flag: the write has completed |
| mem_addr | output | 17 | Address to the memory |
| mem_dq | inout | 8 | Bidirectional data bus to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that the memory drives the bus only while chip-select and output-enable are both low and write-strobe is high. They also assume that the host request fields matter only at the accepting edge. The bench's memory model keeps to the first assumption: it returns a deliberately inverted byte until the address-access time, counted in clocks, has elapsed, so a read sampled too early shows up as a data mismatch. The stimulus raises `req_valid` only while `req_ready` is high and drops it right after acceptance. It sweeps the address over zero, every single-bit address, all-ones and an alternating pattern, and pairs reads directly with writes to exercise the bus release.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_ACCESS,
    ST_RD_TURN
  } seq_state_t;

  // Round a nanosecond minimum up to whole clocks, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned WP_CYC = 11,
  parameter int unsigned AH_CYC = 1,
  parameter int unsigned RD_CYC = 14,
  parameter int unsigned TA_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             wr_finish,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drive_en
);

  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] AH_LOAD = CNT_W'(AH_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  seq_state_t st_q, st_d;
  logic ce_n_d, oe_n_d, we_n_d, drv_d;
  logic ce_n_q, oe_n_q, we_n_q, drv_q;

  // Next-state and timer-load decode
  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    wr_finish = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            st_d    = ST_WR_PULSE;
            tmr_val = WP_LOAD;
          end else begin
            st_d    = ST_RD_ACCESS;
            tmr_val = RD_LOAD;
          end
        end
      end
      ST_WR_PULSE: begin
        if (expired) begin
          st_d     = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = AH_LOAD;
        end
      end
      ST_WR_HOLD: begin
        if (expired) begin
          st_d      = ST_IDLE;
          wr_finish = 1'b1;
        end
      end
      ST_RD_ACCESS: begin
        if (expired) begin
          st_d     = ST_RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = TA_LOAD;
          capture  = 1'b1;
        end
      end
      ST_RD_TURN: begin
        if (expired) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobe levels follow the next state so they leave flops cleanly
  always_comb begin
    ce_n_d = !((st_d == ST_WR_PULSE) || (st_d == ST_RD_ACCESS));
    we_n_d = !(st_d == ST_WR_PULSE);
    oe_n_d = !(st_d == ST_RD_ACCESS);
    drv_d  = (st_d == ST_WR_PULSE) || (st_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      drv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ce_n_q <= ce_n_d;
      oe_n_q <= oe_n_d;
      we_n_q <= we_n_d;
      drv_q  <= drv_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign ce_n      = ce_n_q;
  assign oe_n      = oe_n_q;
  assign we_n      = we_n_q;
  assign drive_en  = drv_q;

endmodule

// File: rtl/sram_bus_io.sv
module sram_bus_io #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              wr_finish,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              wr_done
);

  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvld_q,  done_q;

  always_comb begin
    addr_d  = accept  ? req_addr  : addr_q;
    wdata_d = accept  ? req_wdata : wdata_q;
    rdata_d = capture ? dq_in     : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      rvld_q  <= capture;
      done_q  <= wr_finish;
    end
  end

  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rd_data   = rdata_q;
  assign rd_valid  = rvld_q;
  assign wr_done   = done_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W         = 17,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned CLK_PERIOD_NS  = 5,
  parameter int unsigned T_WP_NS        = 55,
  parameter int unsigned T_DS_NS        = 30,
  parameter int unsigned T_AH_NS        = 5,
  parameter int unsigned T_AA_NS        = 70,
  parameter int unsigned T_OE_NS        = 35,
  parameter int unsigned T_BUS_TURN_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int unsigned WP_CYC  = max2(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_DS_NS, CLK_PERIOD_NS));
  localparam int unsigned AH_CYC  = ns_to_cycles(T_AH_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC  = max2(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                         ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned TA_CYC  = ns_to_cycles(T_BUS_TURN_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = max2(max2(WP_CYC, AH_CYC), max2(RD_CYC, TA_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             accept, capture, wr_finish, tmr_load, expired, drive_en;
  logic [CNT_W-1:0] tmr_val;
  logic [DATA_W-1:0] wdata_q;

  sram_win_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_seq_fsm #(
    .CNT_W  (CNT_W),
    .WP_CYC (WP_CYC),
    .AH_CYC (AH_CYC),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .wr_finish (wr_finish),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .drive_en  (drive_en)
  );

  sram_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) io_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .capture   (capture),
    .wr_finish (wr_finish),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq),
    .addr_out  (mem_addr),
    .wdata_out (wdata_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done)
  );

  assign mem_dq = drive_en ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WP_CYC = 11,
  parameter int unsigned RD_CYC = 14,
  parameter int unsigned TA_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              drive_en,
  input logic [DATA_W-1:0] wdata,
  input logic [ADDR_W-1:0] addr,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              wr_done
);

  logic [15:0] wl_cnt, ol_cnt, oh_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_cnt <= '0;
      ol_cnt <= '0;
      oh_cnt <= 16'hFFFF;
    end else begin
      wl_cnt <= !we_n ? ((wl_cnt == 16'hFFFF) ? wl_cnt : wl_cnt + 1'b1) : 16'd0;
      ol_cnt <= !oe_n ? ((ol_cnt == 16'hFFFF) ? ol_cnt : ol_cnt + 1'b1) : 16'd0;
      oh_cnt <=  oe_n ? ((oh_cnt == 16'hFFFF) ? oh_cnt : oh_cnt + 1'b1) : 16'd0;
    end
  end

  p_we_with_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));

  p_wpulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (wl_cnt == 16'(WP_CYC)));

  p_wdata_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> ($stable(wdata) && drive_en));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!we_n)) |-> $stable(addr));

  p_read_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n && !drive_en));

  p_read_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (ol_cnt == 16'(RD_CYC)));

  p_rdvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> (oh_cnt >= 16'(TA_CYC)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (req_ready ##1 !wr_done));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n && we_n));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC),
  .RD_CYC (RD_CYC),
  .TA_CYC (TA_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ce_n      (mem_ce_n),
  .oe_n      (mem_oe_n),
  .we_n      (mem_we_n),
  .drive_en  (drive_en),
  .wdata     (wdata_q),
  .addr      (mem_addr),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .wr_done   (wr_done)
);

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;

  localparam int PER    = 5;
  localparam int PW_EXP = ((55 + PER - 1) / PER > (30 + PER - 1) / PER) ?
                          (55 + PER - 1) / PER : (30 + PER - 1) / PER;
  localparam int AH_EXP = (5 + PER - 1) / PER;
  localparam int RD_EXP = ((70 + PER - 1) / PER > (35 + PER - 1) / PER) ?
                          (70 + PER - 1) / PER : (35 + PER - 1) / PER;
  localparam int TA_EXP = (20 + PER - 1) / PER;
  localparam int NADDR  = 20;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid, wr_done;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  wire  [7:0]  mem_dq;
  logic        mem_ce_n, mem_oe_n, mem_we_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sram_strobe_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wr_done   (wr_done),
    .mem_addr  (mem_addr),
    .mem_dq    (mem_dq),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: wrong data until the access time has elapsed
  logic [7:0] mdl_mem [int unsigned];
  logic [7:0] mdl_val;
  int         mdl_cnt = 0;
  logic       mdl_drive;

  assign mdl_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq    = mdl_drive ? mdl_val : 8'hzz;

  always @(negedge clk) begin
    logic [7:0] v;
    if (!mem_ce_n && !mem_we_n) mdl_mem[int'(mem_addr)] = mem_dq;
    if (mdl_drive) mdl_cnt++;
    else mdl_cnt = 0;
    v = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00;
    mdl_val = (mdl_cnt >= RD_EXP) ? v : ~v;
  end

  // Bench shadow and monitor
  logic [7:0]  shadow [int unsigned];
  logic [16:0] cur_addr;
  logic [7:0]  cur_wdata, cur_exp;
  bit          mon_en = 0;
  int wl = 0, wh = 1000, ol = 0, oh = 1000;

  always @(negedge clk) begin
    bit rose;
    if (mon_en) begin
      if (!mem_we_n) begin
        wl++; wh = 0;
        if (wl == 1) chk(oh >= TA_EXP, "R7 turnaround", oh, TA_EXP);
        chk(mem_oe_n && !mem_ce_n, "R2 strobes in write", {mem_ce_n, mem_oe_n}, 2'b01);
        chk(mem_dq == cur_wdata, "R3 write data", mem_dq, cur_wdata);
        chk(mem_addr == cur_addr, "R4 addr in pulse", mem_addr, cur_addr);
      end else begin
        if (wl != 0) chk(wl == PW_EXP, "R2 pulse width", wl, PW_EXP);
        wl = 0; wh++;
        if (wh <= AH_EXP) chk(mem_addr == cur_addr, "R4 addr hold", mem_addr, cur_addr);
      end
      if (wr_done) begin
        chk(wh == AH_EXP + 1, "R8 done timing", wh, AH_EXP + 1);
        chk(req_ready, "R8 ready with done", req_ready, 1);
      end
      rose = mem_oe_n && (ol != 0);
      if (!mem_oe_n) begin
        ol++; oh = 0;
        chk(mem_we_n && !mem_ce_n, "R5 strobes in read", {mem_ce_n, mem_we_n}, 2'b01);
      end else begin
        if (rose) chk(ol == RD_EXP, "R5 read width", ol, RD_EXP);
        ol = 0; oh++;
      end
      if (rd_valid || rose) begin
        chk(rd_valid && rose, "R6 valid timing", rd_valid, rose);
        if (rd_valid) chk(rd_data == cur_exp, "R6 read data", rd_data, cur_exp);
      end
    end
  end

  task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int busy;
    while (!req_ready) @(negedge clk);
    cur_addr  = a;
    cur_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else cur_exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    busy = 0;
    while (!req_ready) begin
      busy++;
      @(negedge clk);
    end
    chk(busy == (wr ? PW_EXP + AH_EXP : RD_EXP + TA_EXP), "R9 busy length",
        busy, wr ? PW_EXP + AH_EXP : RD_EXP + TA_EXP);
  endtask

  function automatic logic [16:0] addr_of(input int i);
    if (i == 0) return 17'h00000;
    if (i <= 17) return 17'(1) << (i - 1);
    if (i == 18) return 17'h1FFFF;
    return 17'h0AAAA;
  endfunction

  function automatic logic [7:0] data_of(input logic [16:0] a);
    return 8'(a * 37) ^ a[16:9] ^ 8'h5A;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    cur_addr = '0; cur_wdata = '0; cur_exp = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(req_ready, "R1 ready", req_ready, 1);
    chk(!rd_valid && !wr_done, "R1 flags", {rd_valid, wr_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1;
    for (int i = 0; i < NADDR; i++) access(1'b1, addr_of(i), data_of(addr_of(i)));
    for (int i = 0; i < NADDR; i++) access(1'b0, addr_of(i), 8'h00);
    // Read directly followed by write, then read back (turnaround, R7)
    for (int i = 0; i < NADDR; i++) begin
      access(1'b0, addr_of(i), 8'h00);
      access(1'b1, addr_of(i), ~data_of(addr_of(i)));
      access(1'b0, addr_of(i), 8'h00);
    end
    // Back-to-back writes then back-to-back reads
    for (int i = 0; i < 4; i++) access(1'b1, 17'h10000 + 17'(i), 8'(8'hC0 + i));
    for (int i = 0; i < 4; i++) access(1'b0, 17'h10000 + 17'(i), 8'h00);
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule